// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out, for every pin of a general-purpose I/O bank, the level the pin actually settles at. Three sources feed each pin: the controller's own output driver, an external agent that can leave the pin alone or pull it hard low or high, and the pin's weak pull-up and pull-down resistors. The internal driver is shaped by a polarity inversion and by an open-drain option. With open-drain set, the driver can only sink current, so a high request leaves the pin floating.

From these sources the block produces the settled level and a per-pin undefined flag. An undefined pin is one that is fought over by two drivers, or one that floats with no pull enabled. A separate vector reports driver fights on their own. The settled level is then gated by an input-enable mask and passed back through the polarity inversion. The result is registered as the data-in word. A one-cycle change vector is also registered, so that a downstream event unit can detect edges on data-in.

Top module: `gpio_pin_resolve`

## Requirements
- R1: A pin's internal drive level is its data-out bit XOR its polarity bit. The pin is internally driven when its output-enable bit is 1, and that drive level then appears on `pin_level` when nothing else drives the pin.
- R2: When output type is 1 (open-drain), a pin whose drive level is 1 is not driven internally, so it floats and its pulls decide it. A pin whose drive level is 0 is still driven low.
- R3: A pin that is driven internally and externally (`ext_drv`=1) to different levels sets its `conflict` bit and its `undef` bit. When both drivers agree, neither bit is set.
- R4: On a driven pin that is not in conflict, `pin_level` is the external level (`ext_lvl`, used only where `ext_drv`=1) ORed with the internal level. `ext_lvl` has no effect where `ext_drv`=0.
- R5: A pin that neither side drives reads 1 when its pull-up is enabled, whether or not its pull-down is enabled. It reads 0 with only its pull-down enabled. With no pull enabled it is flagged in `undef`.
- R6: Every pin flagged in `undef` shows 0 on `pin_level`.
- R7: On each rising clock edge out of reset, `din` takes the value (`pin_level` AND `in_en`) XOR `pol`, using the values present before that edge.
- R8: On each rising clock edge out of reset, `din_chg` takes the XOR of the old and the new value of `din`. It is therefore 0 in any cycle where `din` did not change.
- R9: While `rst_n` is 0, `din` and `din_chg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dout | input | PINS | Data-out register |
| pol | input | PINS | Polarity inversion per pin |
| oe | input | PINS | Output enable per pin |
| otype | input | PINS | Output type, 1 = open-drain |
| pu | input | PINS | Pull-up enable |
| pd | input | PINS | Pull-down enable |
| in_en | input | PINS | Input-enable mask for data-in |
| ext_drv | input | PINS | External agent drives the pin |
| ext_lvl | input | PINS | Level driven by the external agent |
| pin_level | output | PINS | Resolved pin level |
| undef | output | PINS | Pin level undefined |
| conflict | output | PINS | Internal and external drivers disagree |
| din | output | PINS | Registered, masked, polarity-corrected input |
| din_chg | output | PINS | Registered change vector of din |

## Verification
`pin_level`, `undef` and `conflict` are combinational, so they are due in the same cycle as the inputs that cause them. The bench compares them a short delay after it applies each new input set, before the next clock edge. `din` and `din_chg` are due one rising edge later. The reference model therefore advances its expected registers at the edge, and these two outputs are compared at the following falling edge, one cycle behind the stimulus that produced them.

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] dout,
  input  logic [PINS-1:0] pol,
  input  logic [PINS-1:0] oe,
  input  logic [PINS-1:0] otype,
  input  logic [PINS-1:0] pu,
  input  logic [PINS-1:0] pd,
  input  logic [PINS-1:0] in_en,
  input  logic [PINS-1:0] ext_drv,
  input  logic [PINS-1:0] ext_lvl,
  output logic [PINS-1:0] pin_level,
  output logic [PINS-1:0] undef,
  output logic [PINS-1:0] conflict,
  output logic [PINS-1:0] din,
  output logic [PINS-1:0] din_chg
);

  logic [PINS-1:0] drv_lvl, drv_en, floating, raw_lvl, din_next;

  assign drv_lvl   = dout ^ pol;
  assign drv_en    = oe & ~(otype & drv_lvl);
  assign conflict  = drv_en & ext_drv & (drv_lvl ^ ext_lvl);
  assign floating  = ~(drv_en | ext_drv);
  assign raw_lvl   = (ext_lvl & ext_drv) | (drv_lvl & drv_en) | (floating & pu);
  assign undef     = conflict | (floating & ~(pu | pd));
  assign pin_level = raw_lvl & ~undef;
  assign din_next  = (pin_level & in_en) ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din     <= '0;
      din_chg <= '0;
    end else begin
      din_chg <= din ^ din_next;
      din     <= din_next;
    end
  end

endmodule

module gpio_pin_resolve_chk #(
  parameter int unsigned PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pol,
  input logic [PINS-1:0] oe,
  input logic [PINS-1:0] pu,
  input logic [PINS-1:0] in_en,
  input logic [PINS-1:0] ext_drv,
  input logic [PINS-1:0] pin_level,
  input logic [PINS-1:0] undef,
  input logic [PINS-1:0] conflict,
  input logic [PINS-1:0] din,
  input logic [PINS-1:0] din_chg
);

  p_conflict_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict & ~undef) == '0);

  p_pullup_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~ext_drv & ~oe & pu & ~pin_level) == '0);

  p_undef_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & undef) == '0);

  p_din_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> din == (($past(pin_level) & $past(in_en)) ^ $past(pol)));

  p_din_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> din_chg == (din ^ $past(din)));

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |-> (din == '0 && din_chg == '0));

endmodule

bind gpio_pin_resolve gpio_pin_resolve_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol(pol), .oe(oe), .pu(pu), .in_en(in_en),
  .ext_drv(ext_drv), .pin_level(pin_level), .undef(undef),
  .conflict(conflict), .din(din), .din_chg(din_chg)
);

// File: tb/tb_gpio_pin_resolve.sv
module tb_gpio_pin_resolve;
  localparam int unsigned PINS = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PINS-1:0] dout = '0, pol = '0, oe = '0, otype = '0, pu = '0, pd = '0;
  logic [PINS-1:0] in_en = '0, ext_drv = '0, ext_lvl = '0;
  logic [PINS-1:0] pin_level, undef, conflict, din, din_chg;

  int checks = 0;
  int failures = 0;
  logic [PINS-1:0] m_lvl, m_und, m_con, m_din_nxt;
  logic [PINS-1:0] e_din = '0, e_chg = '0;

  gpio_pin_resolve #(.PINS(PINS)) dut (
    .clk(clk), .rst_n(rst_n), .dout(dout), .pol(pol), .oe(oe), .otype(otype),
    .pu(pu), .pd(pd), .in_en(in_en), .ext_drv(ext_drv), .ext_lvl(ext_lvl),
    .pin_level(pin_level), .undef(undef), .conflict(conflict),
    .din(din), .din_chg(din_chg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural per-pin model
  task automatic model();
    for (int i = 0; i < PINS; i++) begin
      bit want, drives, fight, lv, ud;
      want   = dout[i] != pol[i];
      drives = oe[i] && !(otype[i] && want);
      fight  = drives && ext_drv[i] && (want != ext_lvl[i]);
      ud = 1'b0;
      lv = 1'b0;
      if (fight) ud = 1'b1;
      else if (drives || ext_drv[i]) lv = (drives && want) || (ext_drv[i] && ext_lvl[i]);
      else if (pu[i]) lv = 1'b1;
      else if (!pd[i]) ud = 1'b1;
      if (ud) lv = 1'b0;
      m_lvl[i] = lv;
      m_und[i] = ud;
      m_con[i] = fight;
      m_din_nxt[i] = (lv && in_en[i]) != pol[i];
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    check({tag, " R7 din"}, din, e_din);
    check({tag, " R8 din_chg"}, din_chg, e_chg);
  endtask

  task automatic settle(string tag);
    #1;
    model();
    check({tag, " R4 level"}, pin_level, m_lvl);
    check({tag, " R5 undef"}, undef, m_und);
    check({tag, " R3 conflict"}, conflict, m_con);
    @(posedge clk);
    e_chg = e_din ^ m_din_nxt;
    e_din = m_din_nxt;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dout = 32'hFFFF_FFFF; pol = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R9 din in reset", din, '0);
    check("R9 din_chg in reset", din_chg, '0);
    dout = '0; pol = '0;
    rst_n = 1'b1;
    settle("post-reset");

    // R1: plain push-pull drive with polarity
    step("R1");
    oe = '1; dout = 32'hA5A5_0F0F; pol = 32'h0000_FFFF; in_en = '1;
    settle("R1");
    check("R1 drive level", pin_level, 32'hA5A5_F0F0);

    // R2: open-drain, high requests float onto pulls
    step("R2");
    otype = '1; dout = 32'hFFFF_0000; pol = '0;
    pu = 32'hFF00_0000; pd = 32'h00FF_0000;
    settle("R2");
    check("R2 open-drain level", pin_level, 32'hFF00_0000);
    check("R2 open-drain undef", undef, 32'h0000_0000);

    // R3/R6: conflicts mark undefined and read 0
    step("R3");
    otype = '0; oe = 32'h0000_00FF; dout = 32'h0000_000F; pol = '0;
    ext_drv = 32'h0000_00FF; ext_lvl = 32'h0000_003C; pu = '1; pd = '0;
    settle("R3");
    check("R3 conflict bits", conflict, 32'h0000_0033);
    check("R6 undefined reads low", pin_level, 32'hFFFF_FF0C);

    // R4: ext_lvl ignored where not driven
    step("R4");
    oe = '0; ext_drv = '0; ext_lvl = '1; pu = '0; pd = '1;
    settle("R4");
    check("R4 ext_lvl ignored", pin_level, '0);

    // R5: pull-up beats pull-down; no pulls -> undef
    step("R5");
    pu = 32'h0000_FFFF; pd = 32'h00FF_00FF;
    settle("R5");
    check("R5 pulls level", pin_level, 32'h0000_FFFF);
    check("R5 floating undef", undef, 32'hFF00_0000);

    // R8: unchanged inputs give zero change vector
    step("R8a");
    settle("R8a");
    step("R8b");
    check("R8 no change", din_chg, '0);
    settle("R8b");

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      step("rand");
      dout = $urandom; pol = $urandom; oe = $urandom; otype = $urandom;
      pu = $urandom; pd = $urandom; in_en = $urandom;
      ext_drv = $urandom; ext_lvl = $urandom;
      settle("rand");
    end
    step("final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule